// File: doc/BRIEF.md
# I2C Controller Byte-Count Sequencer

This block sits behind the register file of an I2C controller and runs the byte-level part of a controller-side transfer. Software writes one control word holding the target address, the direction, the 7/10-bit addressing choice, a byte count, and two end-of-batch policies: reload and automatic stop. The word also carries START and STOP bits that act as one-cycle commands. Transmit bytes arrive through a data-register write port. Receive bytes leave through a one-entry holding register that software reads. The block counts the bytes as they move. When the count runs out, it raises one of three outcomes: transfer complete, reload wait, or an automatic stop.

Toward the bit-level engine the block has two valid/ready channels. The command channel carries the target address, the direction and, for writes, the data byte. Once `cmd_valid` is raised, the command and its byte stay fixed until `cmd_ready` is seen. Software writes to the transmit register and to the control word are the only things that may change it. A read command expects one reply on the response channel. Only one read is outstanding at a time. `rsp_ready` is high exactly while that reply is awaited, so the engine can stall replies for as long as it likes. A further read is issued only after software has drained the holding register, and this is how back-pressure reaches the bus.

Top module: `i2c_xfer_seq`

## Requirements
- R1: Control word read-back keeps only these fields: address [9:0], read-not-write bit 10, ten-bit mode bit 11, byte count [23:16], reload bit 24 and autostop bit 25. All other bits, including START (bit 13) and STOP (bit 14), read as zero.
- R2: A control write with both bit 13 and bit 14 set changes nothing. The read-back, the busy state and the command channel stay as they were.
- R3: With bit 11 clear, `cmd_addr` is the zero-extended value of address bits [7:1]. With bit 11 set, it is all ten bits. `cmd_ten` follows bit 11.
- R4: In a write transfer, `tx_req` is high while the controller is busy, bytes remain and no transmit byte is held. Each held byte is offered on the command channel and stays stable until accepted. Bytes reach the engine in the order they were written.
- R5: In a read transfer, one read command is issued per byte. Each reply lands in the holding register and raises `rx_ne`. The next read is issued only after software has read the previous byte.
- R6: When the last counted byte moves and neither reload nor autostop is set, `flag_tc` rises and the controller stays busy.
- R7: When the last byte moves with autostop set, `stop_pulse` fires once, `flag_stop` rises and busy drops.
- R8: When the last byte moves with reload set and autostop clear, `flag_tcr` rises, `flag_tc` stays low and `tx_req` is low.
- R9: A control write without START or STOP, made while busy with `flag_tcr` set and a nonzero count, loads the new count and clears `flag_tcr`. The transfer then continues with the next batch.
- R10: A transmit byte written while idle is held. It is sent to the engine when START begins a write transfer.
- R11: STOP makes the controller idle, pulses `stop_pulse`, raises `flag_stop` and discards any held transmit byte.
- R12: While `enable` is low, `flag_tc`, `flag_tcr`, `flag_stop` and `tx_req` are forced low.
- R13: A control write without START that changes the byte count while bytes are still due sets the sticky `cnt_err` output. The running count and its read-back keep their old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Peripheral enable; low clears the outcome flags |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word write value |
| ctl_rdata | output | 32 | Control word read-back |
| txd_we | input | 1 | Transmit data write strobe |
| txd_wdata | input | 8 | Transmit byte |
| rxd_re | input | 1 | Receive data read strobe; frees the holding register |
| rxd_rdata | output | 8 | Held receive byte |
| cmd_valid | output | 1 | Command offered to the byte engine |
| cmd_ready | input | 1 | Engine accepts the command |
| cmd_addr | output | 10 | Target address of the command |
| cmd_ten | output | 1 | Command uses 10-bit addressing |
| cmd_rd | output | 1 | Command is a read |
| cmd_data | output | 8 | Byte to send on a write command |
| rsp_valid | input | 1 | Engine presents a read reply |
| rsp_ready | output | 1 | A read reply is awaited |
| rsp_data | input | 8 | Read reply byte |
| busy | output | 1 | Controller is in an active transfer |
| tx_req | output | 1 | A transmit byte is wanted |
| rx_ne | output | 1 | Receive holding register is full |
| flag_tc | output | 1 | Transfer complete |
| flag_tcr | output | 1 | Count reached, waiting for reload |
| flag_stop | output | 1 | Stop was issued |
| stop_pulse | output | 1 | One-cycle stop request to the engine |
| cnt_err | output | 1 | Sticky illegal count change |

## Verification
A wrong remaining count shows up at the ports as an outcome flag that rises one byte early or late. It also shows up as a surplus or missing command, visible in the cycle after the last engine handshake. A lost or stale holding register shows up as a wrong byte on `cmd_data` or `rxd_rdata`, or as `tx_req`/`rx_ne` stuck, within one handshake. The sweep runs every byte count from one to four, in both directions and under all three end-of-batch policies, with the engine stalling one cycle in three. Every byte, flag and stop count is compared against arithmetic expectations.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 10;
  localparam int CNT_W  = 8;
  localparam int DATA_W = 8;

  localparam int B_RD      = 10;
  localparam int B_TEN     = 11;
  localparam int B_START   = 13;
  localparam int B_STOP    = 14;
  localparam int B_CNT     = 16;
  localparam int B_RELOAD  = 24;
  localparam int B_AUTOEND = 25;

  typedef struct packed {
    logic              autoend;
    logic              reload;
    logic [CNT_W-1:0]  nbytes;
    logic              ten;
    logic              rd;
    logic [ADDR_W-1:0] addr;
  } ctl_t;

  function automatic ctl_t ctl_unpack(input logic [WORD_W-1:0] w);
    ctl_t c;
    c.addr    = w[ADDR_W-1:0];
    c.rd      = w[B_RD];
    c.ten     = w[B_TEN];
    c.nbytes  = w[B_CNT +: CNT_W];
    c.reload  = w[B_RELOAD];
    c.autoend = w[B_AUTOEND];
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] ctl_pack(input ctl_t c);
    logic [WORD_W-1:0] w;
    w                = '0;
    w[ADDR_W-1:0]    = c.addr;
    w[B_RD]          = c.rd;
    w[B_TEN]         = c.ten;
    w[B_CNT +: CNT_W] = c.nbytes;
    w[B_RELOAD]      = c.reload;
    w[B_AUTOEND]     = c.autoend;
    return w;
  endfunction

  // 7-bit targets sit in bits [7:1] of the address field
  function automatic logic [ADDR_W-1:0] target_addr(input ctl_t c);
    return c.ten ? c.addr : {{(ADDR_W-7){1'b0}}, c.addr[7:1]};
  endfunction
endpackage

// File: rtl/i2c_seq_ctl.sv
module i2c_seq_ctl
  import i2c_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [WORD_W-1:0] ctl_wdata,
  input  logic              master,
  input  logic              in_flight,
  input  logic              reload_wait,
  output ctl_t              cfg,
  output logic              start_cmd,
  output logic              stop_cmd,
  output logic              extend_cmd,
  output logic              cfg_upd,
  output logic [CNT_W-1:0]  new_cnt,
  output logic              cnt_err,
  output logic [WORD_W-1:0] ctl_rdata
);
  ctl_t wr_fields;
  ctl_t cfg_nxt;
  logic start_bit, stop_bit, legal, cnt_clash;
  logic unused_bits;

  assign unused_bits = ^{ctl_wdata[WORD_W-1:B_AUTOEND+1], ctl_wdata[15], ctl_wdata[12]};

  always_comb begin
    wr_fields  = ctl_unpack(ctl_wdata);
    start_bit  = ctl_wdata[B_START];
    stop_bit   = ctl_wdata[B_STOP];
    legal      = ctl_we && !(start_bit && stop_bit);
    start_cmd  = legal && start_bit;
    stop_cmd   = legal && stop_bit;
    cnt_clash  = legal && !start_bit && !stop_bit && in_flight &&
                 (wr_fields.nbytes != cfg.nbytes);
    extend_cmd = legal && !start_bit && !stop_bit && master && reload_wait &&
                 (wr_fields.nbytes != '0);
    cfg_upd    = legal;
    new_cnt    = wr_fields.nbytes;
    cfg_nxt    = wr_fields;
    if (cnt_clash) cfg_nxt.nbytes = cfg.nbytes;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg     <= '0;
      cnt_err <= 1'b0;
    end else begin
      if (legal) cfg <= cfg_nxt;
      if (cnt_clash) cnt_err <= 1'b1;
    end
  end

  assign ctl_rdata = ctl_pack(cfg);

  p_both_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ctl_wdata[B_START] && ctl_wdata[B_STOP]) |=> $stable(ctl_rdata));

  p_err_sticky_r13: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_err |=> cnt_err);

  p_clash_keeps_r13: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clash |=> ($stable(cfg.nbytes) && cnt_err));
endmodule

// File: rtl/i2c_seq_count.sv
module i2c_seq_count
  import i2c_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             start_cmd,
  input  logic             stop_cmd,
  input  logic             extend_cmd,
  input  logic [CNT_W-1:0] new_cnt,
  input  logic             cfg_reload,
  input  logic             cfg_autoend,
  input  logic             byte_fire,
  output logic             master,
  output logic             cnt_nz,
  output logic             flag_tc,
  output logic             flag_tcr,
  output logic             flag_stop,
  output logic             stop_pulse
);
  logic [CNT_W-1:0] cnt;
  logic byte_ok, last_hit;

  assign cnt_nz   = (cnt != '0);
  assign byte_ok  = byte_fire && master && cnt_nz;
  assign last_hit = byte_ok && (cnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master     <= 1'b0;
      cnt        <= '0;
      flag_tc    <= 1'b0;
      flag_tcr   <= 1'b0;
      flag_stop  <= 1'b0;
      stop_pulse <= 1'b0;
    end else begin
      stop_pulse <= 1'b0;
      if (stop_cmd) begin
        master     <= 1'b0;
        cnt        <= '0;
        flag_stop  <= 1'b1;
        stop_pulse <= 1'b1;
      end else if (start_cmd) begin
        master   <= 1'b1;
        cnt      <= new_cnt;
        flag_tc  <= 1'b0;
        flag_tcr <= 1'b0;
      end else if (extend_cmd) begin
        cnt      <= new_cnt;
        flag_tcr <= 1'b0;
      end else if (byte_ok) begin
        cnt <= cnt - 1'b1;
        if (last_hit) begin
          if (cfg_autoend) begin
            master     <= 1'b0;
            flag_stop  <= 1'b1;
            stop_pulse <= 1'b1;
          end else if (cfg_reload) begin
            flag_tcr <= 1'b1;
          end else begin
            flag_tc <= 1'b1;
          end
        end
      end
      if (!enable) begin
        flag_tc   <= 1'b0;
        flag_tcr  <= 1'b0;
        flag_stop <= 1'b0;
      end
    end
  end

  p_tc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (last_hit && !cfg_autoend && !cfg_reload && enable && !start_cmd && !stop_cmd)
      |=> (flag_tc && master));

  p_autoend_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (last_hit && cfg_autoend && enable && !start_cmd && !stop_cmd)
      |=> (!master && flag_stop && stop_pulse));

  p_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (last_hit && cfg_reload && !cfg_autoend && enable && !start_cmd && !stop_cmd)
      |=> (flag_tcr && !flag_tc && !cnt_nz));

  p_extend_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (extend_cmd && !start_cmd && !stop_cmd) |=> (!flag_tcr && cnt_nz));

  p_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_cmd && enable) |=> (!master && flag_stop && stop_pulse));

  p_en_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!flag_tc && !flag_tcr && !flag_stop));
endmodule

// File: rtl/i2c_seq_path.sv
module i2c_seq_path
  import i2c_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_rd,
  input  logic              master,
  input  logic              cnt_nz,
  input  logic              start_cmd,
  input  logic              stop_cmd,
  input  logic              cfg_upd,
  input  logic              txd_we,
  input  logic [DATA_W-1:0] txd_wdata,
  input  logic              rxd_re,
  input  logic              cmd_ready,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  output logic [DATA_W-1:0] rxd_rdata,
  output logic              rx_ne,
  output logic              tx_empty,
  output logic              cmd_valid,
  output logic [DATA_W-1:0] cmd_data,
  output logic              rsp_ready,
  output logic              byte_fire
);
  logic              txh_v, rxh_v, outst;
  logic [DATA_W-1:0] txh_d, rxh_d;
  logic wr_go, rd_go, tx_fire, rd_fire, rsp_fire;

  assign wr_go     = master && !cfg_rd && cnt_nz && txh_v;
  assign rd_go     = master && cfg_rd && cnt_nz && !outst && !rxh_v;
  assign cmd_valid = wr_go || rd_go;
  assign cmd_data  = cfg_rd ? '0 : txh_d;
  assign tx_fire   = wr_go && cmd_ready;
  assign rd_fire   = rd_go && cmd_ready;
  assign rsp_ready = outst;
  assign rsp_fire  = rsp_valid && outst;
  assign byte_fire = tx_fire || rsp_fire;
  assign tx_empty  = !txh_v;
  assign rx_ne     = rxh_v;
  assign rxd_rdata = rxh_d;

  // transmit holding byte; doubles as the pending byte while idle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txh_v <= 1'b0;
      txh_d <= '0;
    end else if (stop_cmd) begin
      txh_v <= 1'b0;
    end else begin
      if (tx_fire) txh_v <= 1'b0;
      if (txd_we) begin
        txh_v <= 1'b1;
        txh_d <= txd_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outst <= 1'b0;
      rxh_v <= 1'b0;
      rxh_d <= '0;
    end else begin
      if (rd_fire) outst <= 1'b1;
      else if (rsp_fire) outst <= 1'b0;
      if (start_cmd) begin
        rxh_v <= 1'b0;
      end else if (rsp_fire) begin
        rxh_v <= 1'b1;
        rxh_d <= rsp_data;
      end else if (rxd_re) begin
        rxh_v <= 1'b0;
      end
    end
  end

  p_cmd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready && !stop_cmd && !start_cmd && !txd_we && !cfg_upd)
      |=> (cmd_valid && $stable(cmd_data)));

  p_rsp_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_fire && !start_cmd) |=> (rx_ne && !rsp_ready));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stop_cmd |=> !cmd_valid);
endmodule

// File: rtl/i2c_xfer_seq.sv
module i2c_xfer_seq
  import i2c_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              ctl_we,
  input  logic [WORD_W-1:0] ctl_wdata,
  output logic [WORD_W-1:0] ctl_rdata,
  input  logic              txd_we,
  input  logic [DATA_W-1:0] txd_wdata,
  input  logic              rxd_re,
  output logic [DATA_W-1:0] rxd_rdata,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              cmd_ten,
  output logic              cmd_rd,
  output logic [DATA_W-1:0] cmd_data,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              busy,
  output logic              tx_req,
  output logic              rx_ne,
  output logic              flag_tc,
  output logic              flag_tcr,
  output logic              flag_stop,
  output logic              stop_pulse,
  output logic              cnt_err
);
  ctl_t             cfg;
  logic             start_cmd, stop_cmd, extend_cmd, cfg_upd;
  logic [CNT_W-1:0] new_cnt;
  logic             master, cnt_nz, byte_fire, tx_empty;

  i2c_seq_ctl u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_we     (ctl_we),
    .ctl_wdata  (ctl_wdata),
    .master     (master),
    .in_flight  (master && cnt_nz),
    .reload_wait(flag_tcr),
    .cfg        (cfg),
    .start_cmd  (start_cmd),
    .stop_cmd   (stop_cmd),
    .extend_cmd (extend_cmd),
    .cfg_upd    (cfg_upd),
    .new_cnt    (new_cnt),
    .cnt_err    (cnt_err),
    .ctl_rdata  (ctl_rdata)
  );

  i2c_seq_count u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .start_cmd  (start_cmd),
    .stop_cmd   (stop_cmd),
    .extend_cmd (extend_cmd),
    .new_cnt    (new_cnt),
    .cfg_reload (cfg.reload),
    .cfg_autoend(cfg.autoend),
    .byte_fire  (byte_fire),
    .master     (master),
    .cnt_nz     (cnt_nz),
    .flag_tc    (flag_tc),
    .flag_tcr   (flag_tcr),
    .flag_stop  (flag_stop),
    .stop_pulse (stop_pulse)
  );

  i2c_seq_path u_path (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_rd    (cfg.rd),
    .master    (master),
    .cnt_nz    (cnt_nz),
    .start_cmd (start_cmd),
    .stop_cmd  (stop_cmd),
    .cfg_upd   (cfg_upd),
    .txd_we    (txd_we),
    .txd_wdata (txd_wdata),
    .rxd_re    (rxd_re),
    .cmd_ready (cmd_ready),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .rxd_rdata (rxd_rdata),
    .rx_ne     (rx_ne),
    .tx_empty  (tx_empty),
    .cmd_valid (cmd_valid),
    .cmd_data  (cmd_data),
    .rsp_ready (rsp_ready),
    .byte_fire (byte_fire)
  );

  assign cmd_addr = target_addr(cfg);
  assign cmd_ten  = cfg.ten;
  assign cmd_rd   = cfg.rd;
  assign busy     = master;
  assign tx_req   = enable && master && !cfg.rd && cnt_nz && tx_empty;

  p_txreq_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !tx_req);
endmodule

// File: tb/i2c_xfer_seq_bench.sv
module i2c_xfer_seq_bench;
  logic clk = 1'b0;
  logic rst_n, enable, ctl_we, txd_we, rxd_re, cmd_ready, rsp_valid;
  logic [31:0] ctl_wdata, ctl_rdata;
  logic [7:0]  txd_wdata, rxd_rdata, cmd_data, rsp_data;
  logic [9:0]  cmd_addr;
  logic cmd_valid, cmd_ten, cmd_rd, rsp_ready, busy, tx_req, rx_ne;
  logic flag_tc, flag_tcr, flag_stop, stop_pulse, cnt_err;

  always #5 clk = ~clk;

  i2c_xfer_seq u_i2c_xfer_seq (.*);

  int nchk = 0, nfail = 0;
  int wr_cnt, stops, cyc = 0;
  logic [7:0] rd_cmds, rsp_dat, exp_rd;
  logic       rsp_pend, last_ten;
  logic [9:0] last_addr;
  logic [7:0] wr_log [64];

  assign rsp_valid = rsp_pend;
  assign rsp_data  = rsp_dat;

  // engine model: accepts commands, answers reads one cycle later
  always @(posedge clk) begin
    if (!rst_n) begin
      wr_cnt <= 0; stops <= 0; rd_cmds <= 8'h00; rsp_pend <= 1'b0;
      rsp_dat <= 8'h00; last_addr <= '0; last_ten <= 1'b0;
    end else begin
      if (rsp_valid && rsp_ready) rsp_pend <= 1'b0;
      if (cmd_valid && cmd_ready) begin
        last_addr <= cmd_addr;
        last_ten  <= cmd_ten;
        if (cmd_rd) begin
          rsp_pend <= 1'b1;
          rsp_dat  <= 8'hA0 + rd_cmds;
          rd_cmds  <= rd_cmds + 8'h01;
        end else begin
          wr_log[wr_cnt % 64] <= cmd_data;
          wr_cnt <= wr_cnt + 1;
        end
      end
      if (stop_pulse) stops <= stops + 1;
    end
  end

  // engine stalls one cycle in three
  always @(negedge clk) begin
    cyc++;
    cmd_ready = (cyc % 3) != 0;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [9:0] a, input bit rd, input bit ten,
      input int n, input bit rl, input bit ae, input bit st, input bit sp);
    logic [31:0] w;
    w = '0;
    w[9:0] = a; w[10] = rd; w[11] = ten; w[13] = st; w[14] = sp;
    w[23:16] = n[7:0]; w[24] = rl; w[25] = ae;
    return w;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ctl_write(input logic [31:0] w);
    ctl_we = 1'b1; ctl_wdata = w;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic push_tx(input logic [7:0] b);
    txd_we = 1'b1; txd_wdata = b;
    @(negedge clk);
    txd_we = 1'b0;
  endtask

  task automatic wait_tx(input string req);
    for (int k = 0; k < 300 && !tx_req; k++) @(negedge clk);
    if (!tx_req) chk(req, 32'd0, 32'd1);
  endtask

  task automatic pull_rx(input string req);
    for (int k = 0; k < 300 && !rx_ne; k++) @(negedge clk);
    chk(req, {23'd0, rx_ne, rxd_rdata}, {23'd0, 1'b1, exp_rd});
    rxd_re = 1'b1;
    @(negedge clk);
    rxd_re = 1'b0;
    exp_rd = exp_rd + 8'h01;
  endtask

  task automatic stop_and_clear();
    ctl_write(mk(10'h0A4, 0, 0, 0, 0, 0, 0, 1));
    enable = 1'b0; tick(1); enable = 1'b1;
  endtask

  // mode 0: plain, 1: reload, 2: autostop
  task automatic run_case(input bit rd, input int mode, input int n);
    logic [31:0] w;
    logic [4:0]  expf;
    int wr0, st0;
    string tg;
    wr0 = wr_cnt; st0 = stops;
    w = mk(10'h0A4, rd, 0, n, mode == 1, mode == 2, 1, 0);
    ctl_write(w);
    chk("R1 start/stop read zero", ctl_rdata, w & 32'h03FF_0FFF);
    for (int i = 0; i < n; i++) begin
      if (!rd) begin
        wait_tx("R4 tx_req");
        push_tx(8'h30 + 8'(i) + 8'(n * 16));
      end else begin
        pull_rx("R5 read byte");
      end
    end
    tick(12);
    if (!rd) begin
      for (int i = 0; i < n; i++)
        chk("R4 byte order", {24'd0, wr_log[(wr0 + i) % 64]}, 32'h30 + i + n * 16);
      chk("R4 byte count", wr_cnt - wr0, n);
    end
    chk("R3 7-bit addr", {21'd0, last_ten, last_addr}, 32'h052);
    case (mode)
      0: begin expf = 5'b11000; tg = "R6 complete"; end
      1: begin expf = 5'b10100; tg = "R8 reload";   end
      default: begin expf = 5'b00010; tg = "R7 autostop"; end
    endcase
    chk(tg, {27'd0, busy, flag_tc, flag_tcr, flag_stop, tx_req}, {27'd0, expf});
    if (mode == 2) begin
      chk("R7 one stop pulse", stops - st0, 1);
      enable = 1'b0; tick(1); enable = 1'b1;
    end else begin
      stop_and_clear();
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int w0, st0;
    rst_n = 1'b0; enable = 1'b1; ctl_we = 1'b0; ctl_wdata = '0; txd_we = 1'b0;
    txd_wdata = '0; rxd_re = 1'b0; exp_rd = 8'hA0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    chk("R1 reset state", {ctl_rdata[25:0], busy, flag_tc, flag_tcr, flag_stop, tx_req, cmd_valid}, 32'd0);

    // R1 read-back masking
    ctl_write(32'hF7A5_9B6D);
    chk("R1 readback", ctl_rdata, 32'h03A5_0B6D);
    // R2 start and stop together
    w0 = wr_cnt;
    ctl_write(32'h0001_6012);
    tick(4);
    chk("R2 ignored", {ctl_rdata[30:0], busy}, {32'h03A5_0B6D, 1'b0} >> 0 & 32'hFFFF_FFFF);
    chk("R2 busy/cmds", {busy, cmd_valid, 30'(wr_cnt - w0)}, 32'd0);

    // sweep: direction x policy x count
    for (int rd = 0; rd < 2; rd++)
      for (int mode = 0; mode < 3; mode++)
        for (int n = 1; n <= 4; n++)
          run_case(rd[0], mode, n);

    // R3 10-bit address
    ctl_write(mk(10'h2C5, 0, 1, 1, 0, 0, 1, 0));
    push_tx(8'hE1);
    tick(10);
    chk("R3 10-bit addr", {21'd0, last_ten, last_addr}, {21'd0, 1'b1, 10'h2C5});
    stop_and_clear();

    // R10 byte written before START
    w0 = wr_cnt;
    push_tx(8'h5A);
    tick(3);
    chk("R10 held while idle", wr_cnt - w0, 0);
    ctl_write(mk(10'h0A4, 0, 0, 1, 0, 0, 1, 0));
    tick(10);
    chk("R10 pending sent", {wr_cnt - w0 == 1, wr_log[w0 % 64]}, {1'b1, 8'h5A});
    chk("R10 complete", {31'd0, flag_tc}, 32'd1);
    stop_and_clear();

    // R11 STOP discards held byte
    w0 = wr_cnt; st0 = stops;
    push_tx(8'h77);
    ctl_write(mk(10'h0A4, 0, 0, 0, 0, 0, 0, 1));
    tick(1);
    chk("R11 stop", {29'd0, busy, flag_stop, 1'b1}, {29'd0, 1'b0, 1'b1, 1'b1});
    chk("R11 stop pulse", stops - st0, 1);
    enable = 1'b0; tick(1); enable = 1'b1;
    ctl_write(mk(10'h0A4, 0, 0, 1, 0, 0, 1, 0));
    tick(3);
    chk("R11 discarded", {tx_req, 31'(wr_cnt - w0)}, {1'b1, 31'd0});
    push_tx(8'h42);
    tick(10);
    chk("R11 fresh byte", {24'd0, wr_log[w0 % 64]}, 32'h42);
    // R12 enable low clears flags
    chk("R12 tc before", {31'd0, flag_tc}, 32'd1);
    enable = 1'b0; tick(1);
    chk("R12 cleared", {29'd0, flag_tc, flag_tcr, flag_stop}, 32'd0);
    enable = 1'b1;
    stop_and_clear();

    // R9 extension of a read
    ctl_write(mk(10'h0A4, 1, 0, 2, 1, 0, 1, 0));
    pull_rx("R9 batch one");
    pull_rx("R9 batch one");
    tick(6);
    chk("R9 waiting", {30'd0, flag_tcr, busy}, 32'd3);
    ctl_write(mk(10'h0A4, 1, 0, 3, 0, 0, 0, 0));
    chk("R9 tcr cleared", {31'd0, flag_tcr}, 32'd0);
    for (int i = 0; i < 3; i++) pull_rx("R9 batch two");
    tick(6);
    chk("R9 then complete", {29'd0, flag_tc, flag_tcr, cnt_err}, 32'd4);
    stop_and_clear();

    // R13 count change mid-transfer
    w0 = wr_cnt;
    ctl_write(mk(10'h0A4, 0, 0, 3, 0, 0, 1, 0));
    ctl_write(mk(10'h0A4, 0, 0, 5, 0, 0, 0, 0));
    chk("R13 flagged", {23'd0, cnt_err, ctl_rdata[23:16]}, {23'd0, 1'b1, 8'd3});
    for (int i = 0; i < 3; i++) begin
      wait_tx("R13 tx_req");
      push_tx(8'h90 + 8'(i));
    end
    tick(12);
    chk("R13 old count used", {flag_tc, tx_req, 30'(wr_cnt - w0)}, {1'b1, 1'b0, 30'd3});
    stop_and_clear();
    chk("R13 sticky", {31'd0, cnt_err}, 32'd1);

    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule